// File: doc/BRIEF.md
# Bus-Attached Push/Pop FIFO

This block is a single-clock first-in first-out buffer placed between two memory-mapped masters. Its input side is a write-only slave port with no address bits, so every write that the port accepts stores one word. Its output side is a read-only slave port with no address bits, so every read that the port accepts returns the oldest stored word and removes it. Neither port drops or invents data. A write to a full buffer and a read from an empty buffer are held off with a wait-request until space or data is available.

A small addressable status port sits beside the data ports. It reports how many words are stored and holds a sticky event register, an interrupt enable mask and two programmable thresholds. Software uses these to wake up when the buffer nears full or empty, or when a master has been stalled. Words come out in arrival order, and no other signal changes that order.

Top module: `mm_fifo`

## Requirements
- R1: In a cycle where `wr_en` is high and `wr_wait` is low, the value on `wr_data` is stored at the tail of the buffer.
- R2: In a cycle where `rd_en` is high and `rd_wait` is low, `rd_data` carries the oldest stored word in that same cycle, and that word is removed at the next clock edge. Words leave in arrival order.
- R3: While the buffer holds DEPTH words, `wr_wait` equals `wr_en`, and a stalled write changes neither the contents nor the level.
- R4: While the buffer is empty, `rd_wait` equals `rd_en`, and a stalled read removes nothing.
- R5: A write and a read that are both accepted in the same cycle leave the fill level unchanged.
- R6: Status address 0 reads the current fill level, zero-extended. After reset the level is 0, and both wait outputs and `irq` are low.
- R7: Status address 1 is the event register and resets to 0. Its bits are: bit 0 full, bit 1 empty, bit 2 almost-full (level >= almost-full threshold), bit 3 almost-empty (level <= almost-empty threshold), bit 4 write attempted while full, bit 5 read attempted while empty. A bit is set at the clock edge that ends a cycle in which its condition held, and then stays set. Writing 1 to a bit clears it unless its condition holds in that same cycle, in which case the bit stays set.
- R8: Status address 2 is a 6-bit interrupt enable, reset 0, with the same bit layout as the event register. `irq` is high exactly when some event bit and its enable bit are both set.
- R9: Status address 3 holds the almost-full threshold (reset DEPTH-1), and status address 4 holds the almost-empty threshold (reset 1). Both are writable and read back what was written, truncated to the level width.
- R10: Writes to address 0 and to addresses 5 to 7 have no effect. Reads from addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request on the push port |
| wr_data | input | DATA_W | Word to push |
| wr_wait | output | 1 | Push port stall |
| rd_en | input | 1 | Read request on the pop port |
| rd_data | output | DATA_W | Popped word, valid when `rd_wait` is low |
| rd_wait | output | 1 | Pop port stall |
| st_addr | input | 3 | Status register address |
| st_write | input | 1 | Status register write strobe |
| st_wdata | input | ST_W | Status write data |
| st_rdata | output | ST_W | Status read data for `st_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that rst_n is low for at least one edge before any traffic, and that the request strobes and the status write strobe never carry unknown values. They do not assume that a stalled master keeps its request up, so a request may be dropped while the wait-request is high. The stimulus drives every input on the falling edge to a known value, holds reset for several cycles, and deliberately withdraws and reissues stalled requests in the random phase.

// File: rtl/mm_fifo_pkg.sv
package mm_fifo_pkg;
    localparam int EV_FULL   = 0;
    localparam int EV_EMPTY  = 1;
    localparam int EV_AFULL  = 2;
    localparam int EV_AEMPTY = 3;
    localparam int EV_OVF    = 4;
    localparam int EV_UNF    = 5;
    localparam int EV_N      = 6;

    localparam int SA_W = 3;
    typedef enum logic [SA_W-1:0] {
        SA_LEVEL = 3'd0,
        SA_EVENT = 3'd1,
        SA_IEN   = 3'd2,
        SA_AFTH  = 3'd3,
        SA_AETH  = 3'd4
    } st_addr_e;
endpackage

// File: rtl/mm_fifo_store.sv
module mm_fifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } store_t;

    store_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = bump(s_q.wp);
        if (pop)  s_d.rp = bump(s_q.rp);
        unique case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= wdata;
    end

    assign rdata = mem_q[s_q.rp];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_balanced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count));
endmodule

// File: rtl/mm_fifo_csr.sv
module mm_fifo_csr
    import mm_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int ST_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic            full,
    input  logic            empty,
    input  logic            wr_stall,
    input  logic            rd_stall,
    input  logic [SA_W-1:0] st_addr,
    input  logic            st_write,
    input  logic [ST_W-1:0] st_wdata,
    output logic [ST_W-1:0] st_rdata,
    output logic            irq
);
    typedef struct packed {
        logic [EV_N-1:0]  evt;
        logic [EV_N-1:0]  ien;
        logic [CNT_W-1:0] afth;
        logic [CNT_W-1:0] aeth;
    } csr_t;

    csr_t c_d, c_q;
    logic [EV_N-1:0] ev_set, ev_clr;

    always_comb begin
        ev_set            = '0;
        ev_set[EV_FULL]   = full;
        ev_set[EV_EMPTY]  = empty;
        ev_set[EV_AFULL]  = (count >= c_q.afth);
        ev_set[EV_AEMPTY] = (count <= c_q.aeth);
        ev_set[EV_OVF]    = wr_stall;
        ev_set[EV_UNF]    = rd_stall;
        ev_clr = (st_write && st_addr == SA_EVENT) ? st_wdata[EV_N-1:0] : '0;

        c_d     = c_q;
        c_d.evt = (c_q.evt & ~ev_clr) | ev_set;
        if (st_write) begin
            case (st_addr)
                SA_IEN:  c_d.ien  = st_wdata[EV_N-1:0];
                SA_AFTH: c_d.afth = st_wdata[CNT_W-1:0];
                SA_AETH: c_d.aeth = st_wdata[CNT_W-1:0];
                default: ;
            endcase
        end

        st_rdata = '0;
        case (st_addr)
            SA_LEVEL: st_rdata[CNT_W-1:0] = count;
            SA_EVENT: st_rdata[EV_N-1:0]  = c_q.evt;
            SA_IEN:   st_rdata[EV_N-1:0]  = c_q.ien;
            SA_AFTH:  st_rdata[CNT_W-1:0] = c_q.afth;
            SA_AETH:  st_rdata[CNT_W-1:0] = c_q.aeth;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.evt  <= '0;
            c_q.ien  <= '0;
            c_q.afth <= CNT_W'(DEPTH - 1);
            c_q.aeth <= CNT_W'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign irq = |(c_q.evt & c_q.ien);

    for (genvar i = 0; i < EV_N; i++) begin : g_sticky
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (c_q.evt[i] && !ev_clr[i]) |=> c_q.evt[i]);
    end
    assert_full_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> c_q.evt[EV_FULL]);
    assert_stall_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |=> c_q.evt[EV_OVF]);
endmodule

// File: rtl/mm_fifo.sv
module mm_fifo
    import mm_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ST_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_wait,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_wait,
    input  logic [2:0]        st_addr,
    input  logic              st_write,
    input  logic [ST_W-1:0]   st_wdata,
    output logic [ST_W-1:0]   st_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count;
    logic full, empty, push, pop;

    assign wr_wait = wr_en & full;
    assign rd_wait = rd_en & empty;
    assign push    = wr_en & ~full;
    assign pop     = rd_en & ~empty;

    mm_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(wr_data),
        .rdata(rd_data), .count(count), .full(full), .empty(empty)
    );

    mm_fifo_csr #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ST_W(ST_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .count(count), .full(full), .empty(empty),
        .wr_stall(wr_wait), .rd_stall(rd_wait), .st_addr(st_addr),
        .st_write(st_write), .st_wdata(st_wdata), .st_rdata(st_rdata), .irq(irq)
    );

    assert_push_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wait && !rd_en) |=> (count == $past(count) + 1'b1));
    assert_pop_leaves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_wait && !wr_en) |=> (count == $past(count) - 1'b1));
endmodule

// File: tb/sim_mm_fifo.sv
module sim_mm_fifo;
    localparam int PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int ST_W   = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en, rd_en, st_write, wr_wait, rd_wait, irq;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [2:0] st_addr;
    logic [ST_W-1:0] st_wdata, st_rdata;

    always #(PERIOD/2) clk = ~clk;

    mm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ST_W(ST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_wait(wr_wait),
        .rd_en(rd_en), .rd_data(rd_data), .rd_wait(rd_wait), .st_addr(st_addr),
        .st_write(st_write), .st_wdata(st_wdata), .st_rdata(st_rdata), .irq(irq)
    );

    // behavioural reference
    logic [DATA_W-1:0] q[$];
    logic [5:0] m_evt, m_ien;
    int m_af, m_ae;
    int vectors = 0, fails = 0;
    bit done = 0;
    string lvl_tag = "R6";
    string dat_tag = "R2";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] wd, input logic re,
                        input logic [2:0] sa, input logic sw, input logic [15:0] swd);
        int lvl;
        logic fl, em, aw, ar;
        logic [5:0] set, clr;
        logic [31:0] exp_st;
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re; st_addr = sa; st_write = sw; st_wdata = swd;
        #1;
        lvl = q.size();
        fl = (lvl == DEPTH);
        em = (lvl == 0);
        chk("R3", {31'b0, wr_wait}, {31'b0, we & fl});
        chk("R4", {31'b0, rd_wait}, {31'b0, re & em});
        if (re && !em) chk(dat_tag, rd_data, q[0]);
        chk("R8", {31'b0, irq}, {31'b0, |(m_evt & m_ien)});
        case (sa)
            3'd0: begin exp_st = lvl; chk(lvl_tag, {16'b0, st_rdata}, exp_st); end
            3'd1: begin exp_st = {26'b0, m_evt}; chk("R7", {16'b0, st_rdata}, exp_st); end
            3'd2: begin exp_st = {26'b0, m_ien}; chk("R8", {16'b0, st_rdata}, exp_st); end
            3'd3: begin exp_st = m_af; chk("R9", {16'b0, st_rdata}, exp_st); end
            3'd4: begin exp_st = m_ae; chk("R9", {16'b0, st_rdata}, exp_st); end
            default: begin exp_st = 0; chk("R10", {16'b0, st_rdata}, exp_st); end
        endcase
        @(posedge clk);
        aw = we && !fl;
        ar = re && !em;
        set = {re && em, we && fl, lvl <= m_ae, lvl >= m_af, em, fl};
        clr = (sw && sa == 3'd1) ? swd[5:0] : 6'b0;
        m_evt = (m_evt & ~clr) | set;
        if (sw && sa == 3'd2) m_ien = swd[5:0];
        if (sw && sa == 3'd3) m_af = int'(swd[CNT_W-1:0]);
        if (sw && sa == 3'd4) m_ae = int'(swd[CNT_W-1:0]);
        if (ar) void'(q.pop_front());
        if (aw) q.push_back(wd);
    endtask

    task automatic idle_rd(input logic [2:0] sa);
        step(1'b0, 32'h0, 1'b0, sa, 1'b0, 16'h0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 0; rd_en = 0; st_write = 0; st_addr = 0;
        wr_data = 0; st_wdata = 0;
        m_evt = 0; m_ien = 0; m_af = DEPTH - 1; m_ae = 1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6 R7 R8 R9 R10: reset values, all addresses
        for (int a = 0; a < 8; a++) idle_rd(3'(a));

        // R1 R3: fill to full, then stalled writes
        dat_tag = "R1";
        for (int i = 0; i < DEPTH; i++) step(1'b1, 32'hA500_0000 + i, 1'b0, 3'd0, 1'b0, 16'h0);
        for (int i = 0; i < 3; i++) step(1'b1, 32'hDEAD_0000 + i, 1'b0, 3'd1, 1'b0, 16'h0);
        // R7: clearing while full keeps full set
        step(1'b0, 32'h0, 1'b0, 3'd1, 1'b1, 16'h003F);
        idle_rd(3'd1);
        // R1 R4: drain and check order, then stalled reads
        for (int i = 0; i < DEPTH; i++) step(1'b0, 32'h0, 1'b1, 3'd0, 1'b0, 16'h0);
        for (int i = 0; i < 2; i++) step(1'b0, 32'h0, 1'b1, 3'd1, 1'b0, 16'h0);
        dat_tag = "R2";

        // R5: simultaneous push and pop
        lvl_tag = "R5";
        step(1'b1, 32'h1111_0001, 1'b0, 3'd0, 1'b0, 16'h0);
        for (int i = 0; i < 5; i++) step(1'b1, 32'h2222_0000 + i, 1'b1, 3'd0, 1'b0, 16'h0);
        idle_rd(3'd0);

        // R10: writes to level and unmapped addresses ignored
        lvl_tag = "R10";
        step(1'b0, 32'h0, 1'b0, 3'd0, 1'b1, 16'h0007);
        idle_rd(3'd0);
        for (int a = 5; a < 8; a++) step(1'b0, 32'h0, 1'b0, 3'(a), 1'b1, 16'hFFFF);
        for (int a = 0; a < 8; a++) idle_rd(3'(a));
        lvl_tag = "R6";

        // R8 R9: enables and thresholds
        step(1'b0, 32'h0, 1'b0, 3'd2, 1'b1, 16'h0004);
        step(1'b0, 32'h0, 1'b0, 3'd1, 1'b1, 16'h003F);
        idle_rd(3'd1);
        step(1'b0, 32'h0, 1'b0, 3'd3, 1'b1, 16'h0006);
        step(1'b0, 32'h0, 1'b0, 3'd4, 1'b1, 16'h0FF3);
        for (int i = 0; i < 8; i++) step(1'b1, 32'h3333_0000 + i, 1'b0, 3'd1, 1'b0, 16'h0);
        idle_rd(3'd3);
        idle_rd(3'd4);

        // random traffic, requests may be withdrawn while stalled
        for (int i = 0; i < 3000; i++) begin
            logic sw;
            logic [2:0] sa;
            sa = 3'($urandom_range(0, 7));
            sw = ($urandom_range(0, 9) == 0);
            step(($urandom_range(0, 99) < (i < 1500 ? 60 : 40)), $urandom,
                 ($urandom_range(0, 99) < (i < 1500 ? 40 : 60)),
                 sa, sw, 16'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule